// File: doc/BRIEF.md
# Priority Pin Crossbar Allocator

This block decides which on-chip peripheral signal drives each of seventeen physical pins: eight pins of port 0 (pin indices 0 to 7), eight pins of port 1 (indices 8 to 15) and pin 0 of port 2 (index 16). It is purely combinational. Its inputs are the peripheral enables, the SPI wire-count select, a PCA channel count and one skip mask for each of the first two ports. Its outputs are a select code for every pin, and the pin index given to every peripheral signal, with a placed flag and a not-placed flag for each signal.

Four signals sit at fixed locations: UART transmit and receive, and the two comparator outputs. The allocator hands out the remaining signals in a fixed priority order. It scans the pins in ascending index and passes over any pin that is masked or already held by a fixed signal. Every pin that no signal claims is general-purpose I/O. Pins with special analog or clock functions are kept out of the scan by setting their skip bits.

Signal codes, in priority order (code 0 = general-purpose I/O): 1 UART TX, 2 UART RX, 3 comparator async out, 4 comparator sync out, 5 SCK, 6 MISO, 7 MOSI, 8 NSS, 9 SDA, 10 SCL, 11 system clock out, 12 CEX0, 13 CEX1, 14 CEX2, 15 ECI, 16 T0, 17 T1. Signal index k (0 to 16) carries code k+1.

Top module: `xbar_crossbar`

## Requirements
- R1: With every enable low, every pin carries code 0 and no signal has its placed or not-placed flag set.
- R2: When `uartEn` is high, pin 4 carries code 1 and pin 5 carries code 2, whatever the skip masks hold.
- R3: `cmpAEn` puts code 3 on pin 12, and `cmpEn` puts code 4 on pin 13, whatever the skip masks hold.
- R4: Signals with codes 5 to 17 that are requested are taken one at a time in ascending code order. Each one gets the lowest-index pin that is not skipped and not yet used. A pin whose skip bit is set (`skipPort0[i]` for pin i, `skipPort1[i]` for pin 8+i) never carries codes 5 to 17.
- R5: `spiEn` requests SCK, MISO and MOSI together. NSS is also requested only when `spiFourWire` is 1. When `spiFourWire` is 0, NSS is never placed.
- R6: `twoWireEn` requests SDA and SCL together. `uartEn` places TX and RX together.
- R7: When `pcaEn` is high, `pcaChanCount` = n (0 to 3) requests exactly CEX0 up to CEX(n-1). When `pcaEn` is low, no CEX signal is requested.
- R8: Pin 16 has no skip bit, so the allocator can always use it.
- R9: When the usable pins run out, each requested signal left without a pin has `sigMissed` high and `sigValid` low. No two pins ever carry the same non-zero code.
- R10: For every signal k, `sigValid[k]`=1 with `sigPin[k]`=p exactly when pin p carries code k+1. A signal that is not placed reports pin index 0.
- R11: A fixed pin whose owner is disabled is an ordinary pin for the allocator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| uartEn | input | 1 | UART enable (TX and RX at fixed pins) |
| cmpAEn | input | 1 | Comparator asynchronous output enable |
| cmpEn | input | 1 | Comparator synchronous output enable |
| spiEn | input | 1 | SPI enable |
| spiFourWire | input | 1 | 1 = SPI 4-wire (NSS routed), 0 = 3-wire |
| twoWireEn | input | 1 | Two-wire serial bus enable |
| sysclkOutEn | input | 1 | System clock output enable |
| pcaEn | input | 1 | PCA enable |
| pcaChanCount | input | 2 | Number of CEX outputs to route (0 to 3) |
| eciEn | input | 1 | PCA external count input enable |
| t0En | input | 1 | Timer 0 input enable |
| t1En | input | 1 | Timer 1 input enable |
| skipPort0 | input | 8 | Skip mask for pins 0 to 7 |
| skipPort1 | input | 8 | Skip mask for pins 8 to 15 |
| pinSel | output | 17x5 | Select code for each pin |
| sigPin | output | 17x5 | Pin index given to each signal |
| sigValid | output | 17 | Signal was placed |
| sigMissed | output | 17 | Signal was requested but not placed |

## Verification
The assertions treat the block as a settled function of its inputs. They are evaluated only when the inputs are stable, and they take any mix of enables and masks as legal, including masks that starve the allocator. The bench holds the inputs steady for a whole clock period before it samples, and it draws every enable, mask bit and the PCA count from their full ranges. Directed cases add masks with every bit set and masks that cover the fixed pins.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int PORT_PINS   = 8;
  localparam int SKIP_PORTS  = 2;
  localparam int NUM_PINS    = SKIP_PORTS * PORT_PINS + 1;
  localparam int NUM_SIGS    = 17;
  localparam int NUM_FIXED   = 4;
  localparam int PCA_MAX     = 3;
  localparam int PCA_CNT_W   = $clog2(PCA_MAX + 1);
  localparam int CODE_W      = $clog2(NUM_SIGS + 1);
  localparam int PIN_W       = $clog2(NUM_PINS);

  // signal indices in priority order (code = index + 1)
  localparam int SIG_TX     = 0;
  localparam int SIG_RX     = 1;
  localparam int SIG_CMPA   = 2;
  localparam int SIG_CMP    = 3;
  localparam int SIG_SCK    = 4;
  localparam int SIG_MISO   = 5;
  localparam int SIG_MOSI   = 6;
  localparam int SIG_NSS    = 7;
  localparam int SIG_SDA    = 8;
  localparam int SIG_SCL    = 9;
  localparam int SIG_SYSCLK = 10;
  localparam int SIG_CEX0   = 11;
  localparam int SIG_ECI    = 14;
  localparam int SIG_T0     = 15;
  localparam int SIG_T1     = 16;

  // fixed location of each of the first NUM_FIXED signals
  function automatic int fixedPin(input int sig);
    case (sig)
      SIG_TX:   return 4;
      SIG_RX:   return 5;
      SIG_CMPA: return PORT_PINS + 4;
      SIG_CMP:  return PORT_PINS + 5;
      default:  return 0;
    endcase
  endfunction

  typedef struct packed {
    logic [NUM_SIGS-1:0] sigReq;   // signal requested
    logic [NUM_PINS-1:0] pinHold;  // pin held by a fixed signal
  } ctrlStrobes_t;
endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
(
  input  logic                 uartEn,
  input  logic                 cmpAEn,
  input  logic                 cmpEn,
  input  logic                 spiEn,
  input  logic                 spiFourWire,
  input  logic                 twoWireEn,
  input  logic                 sysclkOutEn,
  input  logic                 pcaEn,
  input  logic [PCA_CNT_W-1:0] pcaChanCount,
  input  logic                 eciEn,
  input  logic                 t0En,
  input  logic                 t1En,
  output ctrlStrobes_t         strobes
);
  logic [NUM_SIGS-1:0] reqVec;
  logic [PCA_MAX-1:0]  cexReq;

  genvar g;
  generate
    for (g = 0; g < PCA_MAX; g++) begin : g_cex
      assign cexReq[g] = pcaEn && (int'(pcaChanCount) > g);
    end
  endgenerate

  always_comb begin
    reqVec = '0;
    reqVec[SIG_TX]     = uartEn;
    reqVec[SIG_RX]     = uartEn;
    reqVec[SIG_CMPA]   = cmpAEn;
    reqVec[SIG_CMP]    = cmpEn;
    reqVec[SIG_SCK]    = spiEn;
    reqVec[SIG_MISO]   = spiEn;
    reqVec[SIG_MOSI]   = spiEn;
    reqVec[SIG_NSS]    = spiEn && spiFourWire;
    reqVec[SIG_SDA]    = twoWireEn;
    reqVec[SIG_SCL]    = twoWireEn;
    reqVec[SIG_SYSCLK] = sysclkOutEn;
    for (int c = 0; c < PCA_MAX; c++) reqVec[SIG_CEX0 + c] = cexReq[c];
    reqVec[SIG_ECI]    = eciEn;
    reqVec[SIG_T0]     = t0En;
    reqVec[SIG_T1]     = t1En;
  end

  always_comb begin
    strobes.sigReq  = reqVec;
    strobes.pinHold = '0;
    for (int k = 0; k < NUM_FIXED; k++)
      if (reqVec[k]) strobes.pinHold[fixedPin(k)] = 1'b1;
  end
endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import xbar_pkg::*;
(
  input  ctrlStrobes_t                         strobes,
  input  logic [SKIP_PORTS*PORT_PINS-1:0]      skipAll,
  output logic [NUM_PINS-1:0][CODE_W-1:0]      pinSel,
  output logic [NUM_SIGS-1:0][PIN_W-1:0]       sigPin,
  output logic [NUM_SIGS-1:0]                  sigValid,
  output logic [NUM_SIGS-1:0]                  sigMissed
);
  logic [NUM_PINS-1:0] blocked;

  // the last pin has no skip bit
  assign blocked = {1'b0, skipAll} | strobes.pinHold;

  always_comb begin
    logic [NUM_PINS-1:0] used;
    logic found;
    used      = blocked;
    pinSel    = '0;
    sigPin    = '0;
    sigValid  = '0;
    sigMissed = '0;
    found     = 1'b0;
    // fixed-location signals
    for (int k = 0; k < NUM_FIXED; k++) begin
      if (strobes.sigReq[k]) begin
        pinSel[fixedPin(k)] = CODE_W'(k + 1);
        sigPin[k]           = PIN_W'(fixedPin(k));
        sigValid[k]         = 1'b1;
      end
    end
    // priority scan for the rest
    for (int k = NUM_FIXED; k < NUM_SIGS; k++) begin
      found = 1'b0;
      if (strobes.sigReq[k]) begin
        for (int p = 0; p < NUM_PINS; p++) begin
          if (!found && !used[p]) begin
            found       = 1'b1;
            used[p]     = 1'b1;
            pinSel[p]   = CODE_W'(k + 1);
            sigPin[k]   = PIN_W'(p);
            sigValid[k] = 1'b1;
          end
        end
        sigMissed[k] = !found;
      end
    end
  end
endmodule

// File: rtl/xbar_crossbar.sv
module xbar_crossbar
  import xbar_pkg::*;
(
  input  logic                            uartEn,
  input  logic                            cmpAEn,
  input  logic                            cmpEn,
  input  logic                            spiEn,
  input  logic                            spiFourWire,
  input  logic                            twoWireEn,
  input  logic                            sysclkOutEn,
  input  logic                            pcaEn,
  input  logic [PCA_CNT_W-1:0]            pcaChanCount,
  input  logic                            eciEn,
  input  logic                            t0En,
  input  logic                            t1En,
  input  logic [PORT_PINS-1:0]            skipPort0,
  input  logic [PORT_PINS-1:0]            skipPort1,
  output logic [NUM_PINS-1:0][CODE_W-1:0] pinSel,
  output logic [NUM_SIGS-1:0][PIN_W-1:0]  sigPin,
  output logic [NUM_SIGS-1:0]             sigValid,
  output logic [NUM_SIGS-1:0]             sigMissed
);
  ctrlStrobes_t strobes;

  xbar_ctrl ctrl_i (
    .uartEn(uartEn), .cmpAEn(cmpAEn), .cmpEn(cmpEn), .spiEn(spiEn),
    .spiFourWire(spiFourWire), .twoWireEn(twoWireEn),
    .sysclkOutEn(sysclkOutEn), .pcaEn(pcaEn), .pcaChanCount(pcaChanCount),
    .eciEn(eciEn), .t0En(t0En), .t1En(t1En), .strobes(strobes)
  );

  xbar_alloc alloc_i (
    .strobes(strobes), .skipAll({skipPort1, skipPort0}),
    .pinSel(pinSel), .sigPin(sigPin), .sigValid(sigValid),
    .sigMissed(sigMissed)
  );
endmodule

// File: rtl/xbar_checker.sv
module xbar_checker
  import xbar_pkg::*;
(
  input logic                            uartEn,
  input logic                            cmpAEn,
  input logic                            cmpEn,
  input logic                            spiEn,
  input logic                            spiFourWire,
  input logic                            twoWireEn,
  input logic                            sysclkOutEn,
  input logic                            pcaEn,
  input logic [PCA_CNT_W-1:0]            pcaChanCount,
  input logic                            eciEn,
  input logic                            t0En,
  input logic                            t1En,
  input logic [PORT_PINS-1:0]            skipPort0,
  input logic [PORT_PINS-1:0]            skipPort1,
  input logic [NUM_PINS-1:0][CODE_W-1:0] pinSel,
  input logic [NUM_SIGS-1:0][PIN_W-1:0]  sigPin,
  input logic [NUM_SIGS-1:0]             sigValid,
  input logic [NUM_SIGS-1:0]             sigMissed
);
  logic [SKIP_PORTS*PORT_PINS-1:0] skipVec;
  assign skipVec = {skipPort1, skipPort0};

  always_comb begin
    if (uartEn)
      a_r2_uart_fixed: assert (pinSel[4] == CODE_W'(1) && pinSel[5] == CODE_W'(2))
        else $error("uart pins not fixed");
    if (cmpAEn)
      a_r3_cmpa_fixed: assert (pinSel[PORT_PINS+4] == CODE_W'(3))
        else $error("comparator async pin not fixed");
    if (cmpEn)
      a_r3_cmp_fixed: assert (pinSel[PORT_PINS+5] == CODE_W'(4))
        else $error("comparator sync pin not fixed");
    if (!spiFourWire)
      a_r5_nss_gated: assert (!sigValid[SIG_NSS])
        else $error("NSS placed in 3-wire mode");
    for (int k = 0; k < NUM_SIGS; k++)
      a_r9_flags_exclusive: assert (!(sigValid[k] && sigMissed[k]))
        else $error("signal %0d both placed and missed", k);
    for (int p = 0; p < NUM_PINS; p++) begin
      if (pinSel[p] != '0 && int'(pinSel[p]) <= NUM_SIGS)
        a_r10_index_agrees: assert (sigValid[int'(pinSel[p]) - 1] &&
                                    int'(sigPin[int'(pinSel[p]) - 1]) == p)
          else $error("pin %0d code disagrees with signal index", p);
      a_r9_code_range: assert (int'(pinSel[p]) <= NUM_SIGS)
        else $error("pin %0d carries illegal code", p);
    end
    for (int p = 0; p < SKIP_PORTS*PORT_PINS; p++)
      if (skipVec[p])
        a_r4_skip_respected: assert (int'(pinSel[p]) <= NUM_FIXED)
          else $error("skipped pin %0d allocated", p);
  end
endmodule

bind xbar_crossbar xbar_checker chk_i (.*);

// File: tb/xbar_crossbar_tb.sv
module xbar_crossbar_tb_top;
  import xbar_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic uartEn, cmpAEn, cmpEn, spiEn, spiFourWire, twoWireEn, sysclkOutEn;
  logic pcaEn, eciEn, t0En, t1En;
  logic [1:0] pcaChanCount;
  logic [7:0] skipPort0, skipPort1;
  logic [16:0][4:0] pinSel;
  logic [16:0][4:0] sigPin;
  logic [16:0] sigValid, sigMissed;

  int testsRun = 0;
  int testsFailed = 0;

  xbar_crossbar dut_i (.*);

  // expected values
  logic [16:0][4:0] expSel;
  logic [16:0][4:0] expPin;
  logic [16:0] expValid, expMissed;

  task automatic buildExpected();
    logic [16:0] want;
    logic [16:0] busy;
    want = '0;
    if (uartEn) begin want[0] = 1; want[1] = 1; end
    want[2] = cmpAEn; want[3] = cmpEn;
    if (spiEn) begin want[4] = 1; want[5] = 1; want[6] = 1; want[7] = spiFourWire; end
    if (twoWireEn) begin want[8] = 1; want[9] = 1; end
    want[10] = sysclkOutEn;
    for (int c = 0; c < 3; c++) want[11+c] = pcaEn && (pcaChanCount > c);
    want[14] = eciEn; want[15] = t0En; want[16] = t1En;
    expSel = '0; expPin = '0; expValid = '0; expMissed = '0;
    busy = {1'b0, skipPort1, skipPort0};
    if (want[0]) begin expSel[4] = 1; expPin[0] = 4; expValid[0] = 1; busy[4] = 1; end
    if (want[1]) begin expSel[5] = 2; expPin[1] = 5; expValid[1] = 1; busy[5] = 1; end
    if (want[2]) begin expSel[12] = 3; expPin[2] = 12; expValid[2] = 1; busy[12] = 1; end
    if (want[3]) begin expSel[13] = 4; expPin[3] = 13; expValid[3] = 1; busy[13] = 1; end
    for (int s = 4; s < 17; s++) begin
      if (want[s]) begin
        int slot;
        slot = -1;
        for (int p = 16; p >= 0; p--) if (!busy[p]) slot = p;
        if (slot < 0) expMissed[s] = 1;
        else begin
          busy[slot] = 1; expSel[slot] = 5'(s + 1);
          expPin[s] = 5'(slot); expValid[s] = 1;
        end
      end
    end
  endtask

  task automatic checkAll(input string tag);
    buildExpected();
    testsRun++;
    if (pinSel !== expSel) begin
      testsFailed++;
      $display("FAIL %s pinSel actual=%h expected=%h", tag, pinSel, expSel);
    end
    testsRun++;
    if (sigPin !== expPin) begin
      testsFailed++;
      $display("FAIL %s/R10 sigPin actual=%h expected=%h", tag, sigPin, expPin);
    end
    testsRun++;
    if (sigValid !== expValid || sigMissed !== expMissed) begin
      testsFailed++;
      $display("FAIL %s/R9 flags actual=%h/%h expected=%h/%h",
               tag, sigValid, sigMissed, expValid, expMissed);
    end
  endtask

  task automatic checkOne(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearAll();
    {uartEn, cmpAEn, cmpEn, spiEn, spiFourWire, twoWireEn, sysclkOutEn} = '0;
    {pcaEn, eciEn, t0En, t1En} = '0;
    pcaChanCount = '0; skipPort0 = '0; skipPort1 = '0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #200000;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd7;
    void'($urandom(seed));
    clearAll();
    settle();
    // R1: nothing enabled
    checkAll("R1");
    checkOne("R1 pin0 gpio", int'(pinSel[0]), 0);

    // R2 / R4: crystal-style mask, UART + 4-wire SPI
    clearAll(); uartEn = 1; spiEn = 1; spiFourWire = 1; skipPort0 = 8'b0000_1100;
    settle();
    checkAll("R4");
    checkOne("R2 tx pin", int'(pinSel[4]), 1);
    checkOne("R4 sck pin", int'(sigPin[SIG_SCK]), 0);
    checkOne("R4 mosi pin", int'(sigPin[SIG_MOSI]), 6);
    checkOne("R5 nss pin", int'(sigPin[SIG_NSS]), 7);

    // R5: 3-wire drops NSS, SDA moves up
    spiFourWire = 0; twoWireEn = 1;
    settle();
    checkAll("R5");
    checkOne("R5 nss unplaced", int'(sigValid[SIG_NSS]), 0);
    checkOne("R6 sda pin", int'(sigPin[SIG_SDA]), 7);
    checkOne("R6 scl pin", int'(sigPin[SIG_SCL]), 8);

    // R2 / R3: fixed pins hold even when masked
    clearAll(); uartEn = 1; cmpAEn = 1; cmpEn = 1;
    skipPort0 = 8'hFF; skipPort1 = 8'hFF;
    settle();
    checkAll("R3");
    checkOne("R2 rx pin", int'(pinSel[5]), 2);
    checkOne("R3 cp0a pin", int'(pinSel[12]), 3);
    checkOne("R3 cp0 pin", int'(pinSel[13]), 4);

    // R8 / R9: all masked, only the last pin is left
    clearAll(); spiEn = 1; twoWireEn = 1; t1En = 1;
    skipPort0 = 8'hFF; skipPort1 = 8'hFF;
    settle();
    checkAll("R9");
    checkOne("R8 sck on last pin", int'(sigPin[SIG_SCK]), 16);
    checkOne("R9 miso missed", int'(sigMissed[SIG_MISO]), 1);
    checkOne("R9 t1 missed", int'(sigMissed[SIG_T1]), 1);

    // R7: each PCA channel count
    for (int n = 0; n < 4; n++) begin
      clearAll(); pcaEn = 1; pcaChanCount = 2'(n); eciEn = 1;
      settle();
      checkAll("R7");
      checkOne("R7 eci pin", int'(sigPin[SIG_ECI]), n);
    end
    clearAll(); pcaChanCount = 2'd3; t0En = 1;
    settle();
    checkOne("R7 pca off", int'(sigValid[SIG_CEX0]), 0);

    // R11: fixed pins free when owners are off
    clearAll(); skipPort0 = 8'h0F; spiEn = 1; spiFourWire = 1; sysclkOutEn = 1;
    settle();
    checkAll("R11");
    checkOne("R11 sck on pin4", int'(sigPin[SIG_SCK]), 4);

    // R4 / R6: random mixes
    for (int i = 0; i < 400; i++) begin
      {uartEn, cmpAEn, cmpEn, spiEn, spiFourWire, twoWireEn} = 6'($urandom);
      {sysclkOutEn, pcaEn, eciEn, t0En, t1En} = 5'($urandom);
      pcaChanCount = 2'($urandom);
      skipPort0 = 8'($urandom & $urandom);
      skipPort1 = 8'($urandom & $urandom);
      if (i % 50 == 0) begin skipPort0 = 8'hFF; skipPort1 = 8'hFE; end
      settle();
      checkAll("R4 random");
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule